// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block drives a narrow register port on a PHY. A host presents one 16-bit register read or write at a time on a valid/ready request interface. The block turns it into a chain of phases on the PHY side. Each phase first sets the shared 16-bit input bus, holds it for a programmable number of setup cycles, and then raises one strobe. The block waits for the PHY to raise its acknowledge, drops the strobe, and waits for the acknowledge to fall again. Only after that does the next phase start.

Every access begins with an address phase. A read continues with a single read-command phase, and the PHY output bus is captured while the acknowledge is high. A write continues with a data-capture phase and then a separate write-command phase. Each wait for the acknowledge has its own cycle bound. If a wait runs past that bound, the access is abandoned: all strobes fall, the response reports an error, and the read data is zero.

The controller is a five-state machine:
- ST_IDLE: waiting for a request.
- ST_SETUP: the input bus is driven and held.
- ST_STROBE: a strobe is high and the block waits for the acknowledge to rise.
- ST_RELEASE: the strobe is low and the block waits for the acknowledge to fall.
- ST_RESP: a one-cycle response.

Its transitions are:
- accept: IDLE→SETUP.
- setup_done: SETUP→STROBE.
- ack_seen: STROBE→RELEASE.
- ack_gone: RELEASE→SETUP, for the next phase; or RELEASE→RESP, after the last phase.
- timeout: STROBE→RESP or RELEASE→RESP.
- finish: RESP→IDLE.

The phase register steps ADDR→CMD for a read and ADDR→DATA→CMD for a write.

Top module: `phy_ctl_master`

## Requirements
- R1: After reset the block is idle: `busy`=0, `req_ready`=1, `rsp_valid`=0, all four strobes low and `ctl_din`=0.
- R2: A request is taken on a cycle where `req_valid` and `req_ready` are both high. From the next cycle, `busy` is 1 and `req_ready` is 0 until the response. `rsp_valid` is high for exactly one cycle, and on the following cycle `busy` is 0 again.
- R3: Every access starts with an address phase: `ctl_din` carries `req_addr` and the strobe is `ctl_cap_addr`.
- R4: Before any strobe rises, `ctl_din` has held its value for at least SETUP_CYC cycles. It stays unchanged while the strobe is high.
- R5: A strobe stays high until the acknowledge is seen high, and it is then dropped. The next phase does not begin until the acknowledge is seen low. At most one strobe is high at any time.
- R6: A read performs address then read command (`ctl_rd`, with `ctl_din`=0). It returns the `ctl_dout` value sampled on the cycle the acknowledge is seen high, with `rsp_err`=0.
- R7: A write performs address, then data capture (`ctl_cap_data`), then write command (`ctl_wr`). `ctl_din` equals `req_wdata` in both of the last two phases. The response has `rsp_rdata`=0 and `rsp_err`=0.
- R8: If the acknowledge has not changed after TIMEOUT_CYC cycles of waiting, the access ends at once. All strobes fall, `rsp_err`=1 and `rsp_rdata`=0. For a strobe that is never acknowledged, `rsp_valid` follows exactly TIMEOUT_CYC cycles of strobe-high.
- R9: On success, `rsp_valid` is high in the cycle right after the clock edge at which the final acknowledge is first seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DW | PHY register address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | DW | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Acknowledge timeout occurred |
| busy | output | 1 | Transaction in flight |
| ctl_din | output | DW | Address or data to the PHY |
| ctl_cap_addr | output | 1 | Address capture strobe |
| ctl_cap_data | output | 1 | Data capture strobe |
| ctl_rd | output | 1 | Read command strobe |
| ctl_wr | output | 1 | Write command strobe |
| ctl_ack | input | 1 | PHY acknowledge |
| ctl_dout | input | DW | PHY read data |

## Verification
After an accepting edge, `busy` rises on the next cycle. A strobe rises SETUP_CYC cycles after its phase begins, and the strobe falls one cycle after the acknowledge is seen high. A successful response appears in the cycle right after the edge that sees the last acknowledge low. A timed-out response appears after exactly TIMEOUT_CYC strobe-high cycles. The bench keeps a cycle counter, samples at falling edges, and compares each arrival against the cycle its PHY model predicts: the model's acknowledge-fall cycle plus one, or the TIMEOUT_CYC count of strobe-high samples. The PHY model acknowledges after random delays. Faults that hold the acknowledge low or high cover the abort paths.

// File: rtl/phy_ctl_pkg.sv
package phy_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_RELEASE,
        ST_RESP
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_CMD
    } ctl_phase_e;

endpackage

// File: rtl/ctl_cycle_count.sv
// Counts enabled cycles since the last clear; done marks the LIMIT-th cycle.
module ctl_cycle_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = en && (cnt_q == LAST);
endmodule

// File: rtl/ctl_port_drive.sv
// Decodes the current phase into the PHY-side bus value and strobe.
module ctl_port_drive
    import phy_ctl_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic       active,
    input  logic       strobe_on,
    input  logic       is_write,
    input  ctl_phase_e phase,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] din,
    output logic       cap_addr,
    output logic       cap_data,
    output logic       rd,
    output logic       wr
);
    always_comb begin
        din      = '0;
        cap_addr = 1'b0;
        cap_data = 1'b0;
        rd       = 1'b0;
        wr       = 1'b0;
        if (active) begin
            unique case (phase)
                PH_ADDR: begin
                    din      = addr;
                    cap_addr = strobe_on;
                end
                PH_DATA: begin
                    din      = wdata;
                    cap_data = strobe_on;
                end
                PH_CMD: begin
                    din = is_write ? wdata : '0;
                    rd  = strobe_on && !is_write;
                    wr  = strobe_on && is_write;
                end
                default: din = '0;
            endcase
        end
    end
endmodule

// File: rtl/phy_ctl_master.sv
module phy_ctl_master
    import phy_ctl_pkg::*;
#(
    parameter int DW          = 16,
    parameter int SETUP_CYC   = 2,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_write,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_err,
    output logic          busy,
    output logic [DW-1:0] ctl_din,
    output logic          ctl_cap_addr,
    output logic          ctl_cap_data,
    output logic          ctl_rd,
    output logic          ctl_wr,
    input  logic          ctl_ack,
    input  logic [DW-1:0] ctl_dout
);
    ctl_state_e state_q, state_d;
    ctl_phase_e phase_q, phase_d;

    logic          wr_q;
    logic [DW-1:0] addr_q, wdata_q, rdata_q;
    logic          err_q;

    logic accept, capture, timeout;
    logic setup_done, wait_done;
    logic in_wait, drive_active, strobe_on;

    // Setup hold counter: restarts on every state change.
    ctl_cycle_count #(.LIMIT(SETUP_CYC)) u_setup_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_d != state_q),
        .en   (state_q == ST_SETUP),
        .done (setup_done)
    );

    // Acknowledge wait bound, shared by the rise and fall waits.
    assign in_wait = (state_q == ST_STROBE) || (state_q == ST_RELEASE);

    ctl_cycle_count #(.LIMIT(TIMEOUT_CYC)) u_wait_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (state_d != state_q),
        .en   (in_wait),
        .done (wait_done)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        accept  = 1'b0;
        capture = 1'b0;
        timeout = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_SETUP;
                    phase_d = PH_ADDR;
                end
            end
            ST_SETUP: begin
                if (setup_done) state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (ctl_ack) begin
                    state_d = ST_RELEASE;
                    capture = (phase_q == PH_CMD) && !wr_q;
                end else if (wait_done) begin
                    state_d = ST_RESP;
                    timeout = 1'b1;
                end
            end
            ST_RELEASE: begin
                if (!ctl_ack) begin
                    if (phase_q == PH_CMD) begin
                        state_d = ST_RESP;
                    end else begin
                        state_d = ST_SETUP;
                        phase_d = (phase_q == PH_ADDR && wr_q) ? PH_DATA : PH_CMD;
                    end
                end else if (wait_done) begin
                    state_d = ST_RESP;
                    timeout = 1'b1;
                end
            end
            ST_RESP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State and transaction registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_ADDR;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                rdata_q <= '0;
                err_q   <= 1'b0;
            end
            if (capture) rdata_q <= ctl_dout;
            if (timeout) begin
                err_q   <= 1'b1;
                rdata_q <= '0;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready    = (state_q == ST_IDLE);
        busy         = (state_q != ST_IDLE);
        rsp_valid    = (state_q == ST_RESP);
        rsp_rdata    = rdata_q;
        rsp_err      = err_q;
        strobe_on    = (state_q == ST_STROBE);
        drive_active = (state_q == ST_SETUP) || in_wait;
    end

    ctl_port_drive #(.DW(DW)) u_drive (
        .active   (drive_active),
        .strobe_on(strobe_on),
        .is_write (wr_q),
        .phase    (phase_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .din      (ctl_din),
        .cap_addr (ctl_cap_addr),
        .cap_data (ctl_cap_data),
        .rd       (ctl_rd),
        .wr       (ctl_wr)
    );
endmodule

// File: rtl/phy_ctl_master_chk.sv
module phy_ctl_master_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          req_ready,
    input logic          rsp_valid,
    input logic [DW-1:0] rsp_rdata,
    input logic          rsp_err,
    input logic          busy,
    input logic [DW-1:0] ctl_din,
    input logic          ctl_cap_addr,
    input logic          ctl_cap_data,
    input logic          ctl_rd,
    input logic          ctl_wr,
    input logic          ctl_ack
);
    logic strb;
    assign strb = ctl_cap_addr | ctl_cap_data | ctl_rd | ctl_wr;

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !strb);

    p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (busy && !req_ready));

    p_resp_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && !busy));

    p_din_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && $past(strb)) |-> $stable(ctl_din));

    p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl_cap_addr, ctl_cap_data, ctl_rd, ctl_wr}));

    p_hold_until_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strb && !ctl_ack) |=> (strb || rsp_valid));

    p_drop_after_ack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb && $past(strb)) |-> ($past(ctl_ack) || rsp_valid));

    p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
endmodule

bind phy_ctl_master phy_ctl_master_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata),
    .rsp_err     (rsp_err),
    .busy        (busy),
    .ctl_din     (ctl_din),
    .ctl_cap_addr(ctl_cap_addr),
    .ctl_cap_data(ctl_cap_data),
    .ctl_rd      (ctl_rd),
    .ctl_wr      (ctl_wr),
    .ctl_ack     (ctl_ack)
);

// File: tb/phy_ctl_master_bench.sv
module phy_ctl_master_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int SETUP      = 2;
    localparam int TMO        = 50;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          rsp_err;
    logic          busy;
    logic [DW-1:0] ctl_din;
    logic          ctl_cap_addr, ctl_cap_data, ctl_rd, ctl_wr;
    logic          ctl_ack = 1'b0;
    logic [DW-1:0] ctl_dout = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    phy_ctl_master #(.DW(DW), .SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO)) u_phy_ctl_master (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .busy(busy),
        .ctl_din(ctl_din), .ctl_cap_addr(ctl_cap_addr), .ctl_cap_data(ctl_cap_data),
        .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_ack(ctl_ack), .ctl_dout(ctl_dout)
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc   = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        finish_run();
    end

    // ---------------- PHY model ----------------
    logic [DW-1:0] mem [16];
    logic [DW-1:0] ref_mem [16];
    logic [DW-1:0] a_lat = '0, d_lat = '0, wr_din = '0;
    int  trace [8];
    int  tlen = 0;
    int  fault = 0;      // 0 none, 1 never raise ack, 2 never drop ack
    int  fault_ph = 0;   // 1 cap_addr, 2 cap_data, 3 rd, 4 wr
    int  last_code = 0;
    int  last_fall = -10;
    int  wcnt = 0;
    int  dly = 0;

    function automatic int strobe_code();
        if (ctl_cap_addr) return 1;
        if (ctl_cap_data) return 2;
        if (ctl_rd)       return 3;
        if (ctl_wr)       return 4;
        return 0;
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem[i]     = DW'(16'h1000 + i);
            ref_mem[i] = DW'(16'h1000 + i);
        end
        forever begin
            @(negedge clk);
            if (rst_n) begin
                int code;
                code = strobe_code();
                if (!ctl_ack) begin
                    if (code != 0 && !(fault == 1 && code == fault_ph)) begin
                        if (wcnt >= dly) begin
                            ctl_ack = 1'b1;
                            case (code)
                                1: a_lat = ctl_din;
                                2: d_lat = ctl_din;
                                3: ctl_dout = mem[a_lat[3:0]];
                                4: begin wr_din = ctl_din; mem[a_lat[3:0]] = ctl_din; end
                                default: ;
                            endcase
                            last_code = code;
                            if (tlen < 8) trace[tlen] = code;
                            tlen++;
                            wcnt = 0;
                            dly = int'($urandom % 4);
                        end else wcnt++;
                    end
                end else begin
                    if (code == 0 && !(fault == 2 && last_code == fault_ph)) begin
                        if (wcnt >= dly) begin
                            ctl_ack   = 1'b0;
                            ctl_dout  = DW'($urandom);
                            last_fall = cyc;
                            wcnt = 0;
                            dly = int'($urandom % 4);
                        end else wcnt++;
                    end
                end
            end
        end
    end

    // R4 monitor: bus held SETUP cycles before each strobe rise
    logic [DW-1:0] prev_din = '0;
    int  stable = 0;
    bit  prev_strb = 1'b0;
    always @(negedge clk) begin
        bit s;
        s = ctl_cap_addr | ctl_cap_data | ctl_rd | ctl_wr;
        if (ctl_din == prev_din) stable++;
        else stable = 1;
        if (rst_n && s && !prev_strb)
            chk(stable >= SETUP + 1, "R4 setup before strobe", 32'(stable), 32'(SETUP + 1));
        prev_din  = ctl_din;
        prev_strb = s;
    end

    // ---------------- expected-value functions ----------------
    function automatic int exp_len(input bit w);
        return w ? 3 : 2;
    endfunction

    function automatic int exp_code(input bit w, input int i);
        if (i == 0) return 1;
        if (w) return (i == 1) ? 2 : 4;
        return 3;
    endfunction

    int hi_cnt = 0;

    task automatic run_txn(input bit w, input logic [DW-1:0] a, input logic [DW-1:0] d,
                           output logic [DW-1:0] rd, output bit er, output bit lat_ok);
        int guard;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        tlen = 0;
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R2 busy after accept", {busy, req_ready}, 2'b10);
        hi_cnt = 0;
        guard = 0;
        while (!rsp_valid && guard < 4000) begin
            if (ctl_cap_addr | ctl_cap_data | ctl_rd | ctl_wr) hi_cnt++;
            @(negedge clk);
            guard++;
        end
        rd = rsp_rdata;
        er = rsp_err;
        lat_ok = (cyc == last_fall + 1);
        if (er)
            chk({ctl_cap_addr, ctl_cap_data, ctl_rd, ctl_wr} == 4'b0, "R8 strobes released",
                {ctl_cap_addr, ctl_cap_data, ctl_rd, ctl_wr}, 0);
        @(negedge clk);
        chk(!busy && !rsp_valid && req_ready, "R2 idle after response",
            {busy, rsp_valid, req_ready}, 3'b001);
    endtask

    task automatic good_txn(input bit w, input logic [DW-1:0] a, input logic [DW-1:0] d);
        logic [DW-1:0] rd;
        bit er, lat;
        bit tr_ok;
        run_txn(w, a, d, rd, er, lat);
        chk(!er, w ? "R7 write no error" : "R6 read no error", er, 0);
        chk(lat, "R9 response one cycle after final ack low", 32'(cyc), 32'(last_fall + 2));
        tr_ok = (tlen == exp_len(w));
        for (int i = 0; i < exp_len(w) && i < 8; i++) if (trace[i] != exp_code(w, i)) tr_ok = 1'b0;
        chk(tr_ok, w ? "R7 phase order addr,data,write" : "R6 phase order addr,read", 32'(tlen), 32'(exp_len(w)));
        chk(a_lat == a, "R3 address phase carries req_addr", a_lat, a);
        if (w) begin
            ref_mem[a[3:0]] = d;
            chk(d_lat == d && wr_din == d, "R7 data and write phases carry wdata", {d_lat, wr_din}, {d, d});
            chk(rd == '0, "R7 write returns zero data", rd, 0);
        end else begin
            chk(rd == ref_mem[a[3:0]], "R6 read data", rd, ref_mem[a[3:0]]);
        end
    endtask

    initial begin
        logic [DW-1:0] rd;
        bit er, lat;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!busy && req_ready && !rsp_valid && ctl_din == '0 &&
            {ctl_cap_addr, ctl_cap_data, ctl_rd, ctl_wr} == 4'b0,
            "R1 reset state", {busy, req_ready, rsp_valid}, 3'b010);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && req_ready, "R1 idle after reset release", {busy, req_ready}, 2'b01);

        // directed
        good_txn(1'b1, 16'h0005, 16'hBEEF);
        good_txn(1'b0, 16'h0005, 16'h0000);
        good_txn(1'b1, 16'hFFFF, 16'h0000);
        good_txn(1'b0, 16'hFFFF, 16'h0000);
        good_txn(1'b1, 16'h1230, 16'hFFFF);
        good_txn(1'b0, 16'h1230, 16'h0000);

        // random mix
        for (int n = 0; n < 40; n++) begin
            bit w;
            w = 1'($urandom);
            good_txn(w, DW'($urandom), DW'($urandom));
        end

        // R8: address phase never acknowledged on a write
        fault = 1; fault_ph = 1;
        run_txn(1'b1, 16'h0007, 16'hAAAA, rd, er, lat);
        chk(er, "R8 error on addr timeout", er, 1);
        chk(rd == '0, "R8 zero data on error", rd, 0);
        chk(hi_cnt == TMO, "R8 timeout after TIMEOUT_CYC strobe cycles", 32'(hi_cnt), 32'(TMO));
        fault = 0;
        good_txn(1'b0, 16'h0007, 16'h0000);

        // R8: write command never acknowledged -> no store
        fault = 1; fault_ph = 4;
        run_txn(1'b1, 16'h0009, 16'h5555, rd, er, lat);
        chk(er && rd == '0, "R8 error on write-phase timeout", {er, rd}, 17'h10000);
        fault = 0;
        good_txn(1'b0, 16'h0009, 16'h0000);

        // R8: read command never acknowledged
        fault = 1; fault_ph = 3;
        run_txn(1'b0, 16'h0003, 16'h0000, rd, er, lat);
        chk(er && rd == '0, "R8 error on read-phase timeout", {er, rd}, 17'h10000);
        fault = 0;

        // R8: acknowledge stuck high after address phase
        fault = 2; fault_ph = 1;
        run_txn(1'b0, 16'h0004, 16'h0000, rd, er, lat);
        chk(er && rd == '0, "R8 error on ack-stuck-high", {er, rd}, 17'h10000);
        fault = 0;
        repeat (10) @(negedge clk);
        chk(!ctl_ack, "R5 model ack cleared", ctl_ack, 0);
        good_txn(1'b0, 16'h0004, 16'h0000);
        good_txn(1'b1, 16'h0004, 16'h3C3C);
        good_txn(1'b0, 16'h0004, 16'h0000);

        finish_run();
    end
endmodule